// File: doc/BRIEF.md
# Segmented Window Envelope Shaper

The shaper is a triggerable envelope source. It holds 1024 words of window storage that contain any number of segments. A segment is a header word followed by complex samples at the next addresses. A trigger names the address of a header. The block decodes that header and fetches the segment's samples one at a time. It passes them through a cascaded comb/integrator interpolator whose order and rate the header selects. It then scales the result down by a power of two and delivers one complex envelope sample per cycle.

The header can ask for the interpolator to be cleared, so that the envelope rises from zero. It can instead ask the block to keep its settings and filter state, so that the segment joins smoothly onto the one that came before. After the last sample the block feeds either zeros, so that the envelope decays back to zero, or the last sample again, which gives continuous output. A new trigger always takes effect, even while an earlier segment is still playing.

The envelope leaves the block on a valid/ready stream. `env_valid` rises one cycle after reset and stays high. Nothing inside the block advances in a cycle where `env_ready` is low, so the sample on offer stays in place until it is taken. The trigger is a valid/ready input as well, and its ready signal follows `env_ready`.

Top module: `ws_shaper`

## Requirements
- R1: A sample word carries signed I in bits [15:0] and signed Q in bits [31:16]. A header word carries the length in bits [9:0], the rate minus one in bits [21:10], the shift in bits [27:22], the order in bits [29:28], the head flag in bit 30 and the tail flag in bit 31.
- R2: A trigger is taken on a clock edge where `trig_valid` and `trig_ready` are both high. The header is read at `trig_addr`, and the samples are read from the addresses that follow it, wrapping modulo 1024.
- R3: When the head flag is set, the rate, order and shift are loaded from the header and all interpolator state is cleared. Output is zero after the edge that takes the trigger, and the first sample appears at the output one edge later.
- R4: When the head flag is clear, the rate, order and shift already in use are kept and the interpolator state is not cleared. The segment's first sample enters at the next input-sample slot.
- R5: Each input sample occupies rate (the header field plus one, from 1 to 4096) output cycles.
- R6: Order 0 is a zero-order hold: the output equals the current sample shifted right by the shift value.
- R7: Order n uses n+1 comb and n+1 integrator stages and has a DC gain of rate^n. With order 1, the output ramps linearly over rate cycles from one sample value to the next.
- R8: The output is the interpolator result shifted arithmetically right by the shift value (0 to 63), keeping the low 16 bits.
- R9: When the tail flag is set, zeros are fed after the last sample, and the envelope returns to zero. With order 0 the output is zero from edge length*rate+1 after the trigger edge.
- R10: When the tail flag is clear, the last sample is fed again and again, so the output holds steady.
- R11: A trigger that arrives while a segment is playing abandons that segment at once.
- R12: `env_valid` is high from the first edge after reset. While `env_ready` is low, the outputs stay unchanged, no state advances, and `trig_ready` is low.
- R13: After reset both output lanes are zero.
- R14: With order 3 and rate 4096 (a gain of 2^36), no internal overflow occurs: a shift of 36 gives back the input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Write strobe for the window storage |
| mem_waddr | input | 10 | Write address |
| mem_wdata | input | 32 | Header or sample word to store |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | High when a trigger can be taken |
| trig_addr | input | 10 | Header address of the segment to play |
| env_valid | output | 1 | Envelope sample available |
| env_ready | input | 1 | Downstream takes the envelope sample |
| env_i | output | 16 | Envelope in-phase part, signed |
| env_q | output | 16 | Envelope quadrature part, signed |

## Verification
The hardest case to reach from the ports is a segment with a clear head flag that arrives partway through another segment. Whether the block keeps the old rate and joins at the next input slot depends on where the rate counter stands at that moment. The stimulus first starts a head segment with rate 4, then counts edges so that the second trigger lands exactly on the last phase of an input period. The header of the second segment asks for rate 1, so any wrong reload of the settings shows up as an early change of value. The order-3, rate-4096 case is driven with constant samples held for more than four input periods, so the accumulators reach their full 2^36 gain.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int LEN_W   = 10;
  localparam int RATE_W  = 12;
  localparam int SHIFT_W = 6;
  localparam int ORDER_W = 2;

  // Field placement is fixed by the stored header layout.
  typedef struct packed {
    logic               tail;
    logic               head;
    logic [ORDER_W-1:0] order;
    logic [SHIFT_W-1:0] shift;
    logic [RATE_W-1:0]  rate_m1;
    logic [LEN_W-1:0]   len;
  } seg_hdr_t;
endpackage

// File: rtl/ws_window_mem.sv
module ws_window_mem #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_hdr,
  input  logic [ADDR_W-1:0] raddr_smp,
  output logic [WORD_W-1:0] rdata_hdr,
  output logic [WORD_W-1:0] rdata_smp
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata_hdr = store[raddr_hdr];
  assign rdata_smp = store[raddr_smp];
endmodule

// File: rtl/ws_sequencer.sv
module ws_sequencer
  import ws_pkg::*;
#(
  parameter int ADDR_W   = LEN_W,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       trig_fire,
  input  logic [ADDR_W-1:0]          start_addr,
  input  seg_hdr_t                   hdr,
  input  logic [2*SAMPLE_W-1:0]      smp_word,
  output logic [ADDR_W-1:0]          rd_ptr,
  output logic                       slot,
  output logic                       clr,
  output logic signed [SAMPLE_W-1:0] x_i,
  output logic signed [SAMPLE_W-1:0] x_q,
  output logic [ORDER_W-1:0]         order,
  output logic [SHIFT_W-1:0]         shift
);
  logic [RATE_W-1:0]          ph, rate_m1;
  logic [LEN_W-1:0]           remain;
  logic                       tail_q;
  logic signed [SAMPLE_W-1:0] last_i, last_q;
  logic                       has_smp;
  logic [RATE_W-1:0]          ph_next;

  assign has_smp = (remain != '0);
  assign slot    = (ph == '0);
  assign clr     = trig_fire & hdr.head;
  assign ph_next = (ph == rate_m1) ? '0 : ph + 1'b1;

  always_comb begin
    if (has_smp) begin
      x_i = smp_word[SAMPLE_W-1:0];
      x_q = smp_word[2*SAMPLE_W-1:SAMPLE_W];
    end else if (tail_q) begin
      x_i = '0;
      x_q = '0;
    end else begin
      x_i = last_i;
      x_q = last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      rate_m1 <= '0;
      order   <= '0;
      shift   <= '0;
      tail_q  <= 1'b1;
      rd_ptr  <= '0;
      remain  <= '0;
      last_i  <= '0;
      last_q  <= '0;
    end else if (adv) begin
      if (clr) begin
        ph      <= '0;
        rate_m1 <= hdr.rate_m1;
        order   <= hdr.order;
        shift   <= hdr.shift;
        last_i  <= '0;
        last_q  <= '0;
      end else begin
        ph <= ph_next;
        if (slot) begin
          last_i <= x_i;
          last_q <= x_q;
        end
      end
      if (trig_fire) begin
        rd_ptr <= start_addr + 1'b1;
        remain <= hdr.len;
        tail_q <= hdr.tail;
      end else if (slot && has_smp) begin
        rd_ptr <= rd_ptr + 1'b1;
        remain <= remain - 1'b1;
      end
    end
  end

  // R5: the phase counter never runs past the active rate
  a_r5_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= rate_m1);

  // R2: samples are fetched from consecutive, wrapping addresses
  a_r2_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && slot && has_smp && !trig_fire) |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

  // R10: once the samples run out without a tail, the fed value stays put
  a_r10_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !trig_fire && !has_smp && !tail_q) |=> (x_i == $past(x_i) && x_q == $past(x_q)));
endmodule

// File: rtl/ws_cic.sv
module ws_cic
  import ws_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int STAGES   = 1 << ORDER_W,
  parameter int ACC_W    = SAMPLE_W + RATE_W * (STAGES - 1) + STAGES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       clr,
  input  logic                       slot,
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic [ORDER_W-1:0]         order,
  input  logic [SHIFT_W-1:0]         shift,
  output logic signed [SAMPLE_W-1:0] y
);
  logic signed [ACC_W-1:0] dly   [STAGES];
  logic signed [ACC_W-1:0] integ [STAGES];
  logic signed [ACC_W-1:0] cch   [STAGES+1];
  logic signed [ACC_W-1:0] ich   [STAGES+1];
  logic signed [ACC_W-1:0] y_acc;

  assign cch[0] = {{(ACC_W-SAMPLE_W){x[SAMPLE_W-1]}}, x};
  assign ich[0] = slot ? cch[STAGES] : '0;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [ORDER_W-1:0] K_IDX = ORDER_W'(k);
    logic active;
    assign active   = (K_IDX <= order);
    assign cch[k+1] = active ? (cch[k] - dly[k]) : cch[k];
    assign ich[k+1] = active ? (integ[k] + ich[k]) : ich[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (adv && clr)) begin
      for (int k = 0; k < STAGES; k++) begin
        dly[k]   <= '0;
        integ[k] <= '0;
      end
      y_acc <= '0;
    end else if (adv) begin
      for (int k = 0; k < STAGES; k++) begin
        if (slot) dly[k] <= cch[k];
        integ[k] <= ich[k+1];
      end
      y_acc <= ich[STAGES];
    end
  end

  assign y = SAMPLE_W'(y_acc >>> shift);

  // R6: in zero-order hold the result changes only on an input slot
  a_r6_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !slot && order == '0) |=> $stable(y_acc));
endmodule

// File: rtl/ws_shaper.sv
module ws_shaper
  import ws_pkg::*;
#(
  parameter int ADDR_W   = LEN_W,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_waddr,
  input  logic [2*SAMPLE_W-1:0] mem_wdata,
  input  logic                trig_valid,
  output logic                trig_ready,
  input  logic [ADDR_W-1:0]   trig_addr,
  output logic                env_valid,
  input  logic                env_ready,
  output logic [SAMPLE_W-1:0] env_i,
  output logic [SAMPLE_W-1:0] env_q
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int LANES  = 2;

  logic [WORD_W-1:0]          hdr_word, smp_word;
  logic [ADDR_W-1:0]          rd_ptr;
  logic                       adv, trig_fire, slot, clr;
  logic [ORDER_W-1:0]         order;
  logic [SHIFT_W-1:0]         shift;
  logic signed [SAMPLE_W-1:0] lane_x [LANES];
  logic signed [SAMPLE_W-1:0] lane_y [LANES];

  assign adv        = env_ready;
  assign trig_ready = env_ready;
  assign trig_fire  = trig_valid & env_ready;

  ws_window_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_hdr(trig_addr), .raddr_smp(rd_ptr),
    .rdata_hdr(hdr_word), .rdata_smp(smp_word)
  );

  ws_sequencer #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .trig_fire(trig_fire),
    .start_addr(trig_addr), .hdr(seg_hdr_t'(hdr_word)), .smp_word(smp_word),
    .rd_ptr(rd_ptr), .slot(slot), .clr(clr),
    .x_i(lane_x[0]), .x_q(lane_x[1]), .order(order), .shift(shift)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ws_cic #(.SAMPLE_W(SAMPLE_W)) u_cic (
      .clk(clk), .rst_n(rst_n), .adv(adv), .clr(clr), .slot(slot),
      .x(lane_x[l]), .order(order), .shift(shift), .y(lane_y[l])
    );
  end

  assign env_i = lane_y[0];
  assign env_q = lane_y[1];

  always_ff @(posedge clk) begin
    if (!rst_n) env_valid <= 1'b0;
    else        env_valid <= 1'b1;
  end

  // R12: an offered sample that is not taken stays in place
  a_r12_stall_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    (env_valid && !env_ready) |=> ($stable(env_i) && $stable(env_q)));
endmodule

// File: tb/sim_ws_shaper.sv
module sim_ws_shaper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_we = 1'b0;
  logic [9:0]  mem_waddr = '0;
  logic [31:0] mem_wdata = '0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [9:0]  trig_addr = '0;
  logic        env_valid;
  logic        env_ready = 1'b1;
  logic [15:0] env_i, env_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ws_shaper u0 (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_addr(trig_addr), .env_valid(env_valid), .env_ready(env_ready),
    .env_i(env_i), .env_q(env_q)
  );

  // columns: start, order, rate, shift, tail, len, sample_a, sample_b, probe, expected_i, req
  localparam int NV = 19;
  localparam int VEC [NV][11] = '{
    '{16,   0, 4,    0,  1, 2, 1234, -567, 1,     1234, 6},  // R6 R3
    '{16,   0, 4,    0,  1, 2, 1234, -567, 4,     1234, 5},  // R5
    '{16,   0, 4,    0,  1, 2, 1234, -567, 5,     -567, 5},  // R5 R1
    '{16,   0, 4,    0,  1, 2, 1234, -567, 9,     0,    9},  // R9
    '{32,   0, 4,    0,  0, 2, 800,  -300, 20,    -300, 10}, // R10
    '{48,   1, 4,    2,  1, 2, 1000, 1000, 1,     250,  7},  // R7
    '{48,   1, 4,    2,  1, 2, 1000, 1000, 4,     1000, 7},  // R7
    '{48,   1, 4,    2,  1, 2, 1000, 1000, 6,     1000, 7},  // R7
    '{48,   1, 4,    2,  1, 2, 1000, 1000, 10,    500,  9},  // R9
    '{48,   1, 4,    2,  1, 2, 1000, 1000, 12,    0,    9},  // R9
    '{64,   3, 2,    0,  0, 2, 100,  100,  30,    800,  7},  // R7
    '{80,   3, 2,    3,  0, 2, 100,  100,  30,    100,  8},  // R8
    '{96,   0, 1,    4,  0, 1, 1600, 0,    3,     100,  8},  // R8
    '{1022, 0, 1,    0,  1, 2, 55,   66,   1,     55,   2},  // R2
    '{1022, 0, 1,    0,  1, 2, 55,   66,   2,     66,   2},  // R2
    '{1022, 0, 1,    0,  1, 2, 55,   66,   3,     0,    2},  // R2
    '{128,  3, 4096, 36, 0, 2, 1000, 1000, 20480, 1000, 14}, // R14
    '{144,  0, 4096, 0,  1, 1, 77,   0,    4096,  77,   5},  // R5
    '{144,  0, 4096, 0,  1, 1, 77,   0,    4097,  0,    9}   // R9
  };

  function automatic logic [31:0] hdr_word(input int len, input int rate, input int sh,
                                           input int ord, input bit head, input bit tail);
    return {tail, head, 2'(ord), 6'(sh), 12'(rate - 1), 10'(len)};
  endfunction

  function automatic logic [31:0] smp_word(input int v);
    return {16'(-v), 16'(v)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    mem_waddr = 10'(a);
    mem_wdata = d;
    mem_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_we    = 1'b0;
  endtask

  task automatic fire(input int a);
    trig_addr  = 10'(a);
    trig_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic check_iq(input string req, input int exp);
    check(req, env_i, 16'(exp));
    check(req, env_q, 16'(-exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1);
    // R13 R12: idle output after reset
    check_iq("R13", 0);
    check("R12", {15'd0, env_valid}, 16'd1);
    check("R12", {15'd0, trig_ready}, 16'd1);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][0], hdr_word(VEC[v][5], VEC[v][2], VEC[v][3], VEC[v][1], 1'b1, VEC[v][4] != 0));
      wr((VEC[v][0] + 1) % 1024, smp_word(VEC[v][6]));
      wr((VEC[v][0] + 2) % 1024, smp_word(VEC[v][7]));
      fire(VEC[v][0]);
      check_iq($sformatf("R3 clear before R%0d", VEC[v][10]), 0);
      step(VEC[v][8]);
      check_iq($sformatf("R%0d vector %0d", VEC[v][10], v), VEC[v][9]);
    end

    // R4: head-clear segment keeps rate 4, state, and joins at the next slot
    wr(200, hdr_word(1, 4, 0, 0, 1'b1, 1'b0));
    wr(201, smp_word(300));
    wr(210, hdr_word(2, 1, 0, 0, 1'b0, 1'b0));
    wr(211, smp_word(700));
    wr(212, smp_word(900));
    fire(200);
    step(7);
    check_iq("R10 before join", 300);
    fire(210);
    check_iq("R4 state kept", 300);
    step(4);
    check_iq("R4 old rate kept", 700);
    step(1);
    check_iq("R4 next sample", 900);

    // R11: a head trigger abandons a long running segment
    wr(230, hdr_word(1, 8, 0, 0, 1'b1, 1'b0));
    wr(231, smp_word(111));
    wr(240, hdr_word(1, 1, 0, 0, 1'b1, 1'b1));
    wr(241, smp_word(222));
    fire(230);
    step(2);
    check_iq("R6 before abort", 111);
    fire(240);
    check_iq("R11 cleared", 0);
    step(1);
    check_iq("R11 new segment", 222);
    step(1);
    check_iq("R11 tail", 0);

    // R12: back-pressure freezes the ramp and blocks triggers
    fire(48);
    step(2);
    check_iq("R7 ramp", 500);
    env_ready  = 1'b0;
    trig_addr  = 10'd16;
    trig_valid = 1'b1;
    #1;
    check("R12 trig_ready", {15'd0, trig_ready}, 16'd0);
    step(3);
    check_iq("R12 stalled", 500);
    trig_valid = 1'b0;
    env_ready  = 1'b1;
    step(1);
    check_iq("R12 resumed", 750);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule